// File: doc/BRIEF.md
# Multi-Mode Fixed-Point MAC Pipeline with Rotating Partial Sums

This block is a streaming dot-product engine that computes output neurons for both convolution and fully connected layers on one datapath. Each accepted input beat carries one vector of `VEC` signed 16-bit features, which all `LANES` lanes share. It also carries one weight vector of `VEC` elements for each lane. Every lane multiplies its weights with the features element by element and reduces the products through a registered adder tree.

The running sum is not held in a single accumulator. Tree outputs enter a circular delay line of `DEPTH` 40-bit entries. Each new partial sum is added to the oldest entry, which leaves the line, and the result goes in at the other end. The adder therefore never waits on its own result from the previous cycle. When the last beat of a neuron has passed through, the `DEPTH` entries are summed in one step, clipped to 32 bits, and the lane results are sent out one lane at a time.

A job is one output neuron per lane. The job is set up through a plain config port while the engine is idle. In convolution mode the beat count is K·K·C'. In fully connected mode it is C'.

An input beat transfers on a rising edge where `feat_valid`, `wgt_valid` and `in_ready` are all high. `in_ready` depends only on internal state and never on the valids. A result stays on `out_data`/`out_lane` with `out_valid` high until `out_ready` takes it.

Top module: `mac_delay_engine`

## Requirements
- R1: During reset and immediately after it, `busy`, `in_ready` and `out_valid` are low.
- R2: A config is accepted only when `busy` is low and `cfg_valid` is high. The job then expects `cfg_k*cfg_k*cfg_cv` beats when `cfg_conv`=1, or `cfg_cv` beats when `cfg_conv`=0. A computed count of zero is treated as one beat. A `cfg_valid` pulse while `busy` is high has no effect on the running job.
- R3: For lane l, the result equals the sum over all beats and over i of feature element i times weight element i of lane l. Feature element i sits in `feat_data[16*i +: 16]`. Weight element i of lane l sits in `wgt_data[16*(l*VEC+i) +: 16]`. All values are two's complement. Results appear in lane order 0 to LANES-1, with `out_lane` giving the lane.
- R4: After an accepted beat, `in_ready` is low in the next cycle. At most one beat is accepted every two cycles.
- R5: Cycles with either input valid low do not change the result, whatever the gap pattern.
- R6: A result outside the signed 32-bit range is clipped to 2147483647 or -2147483648.
- R7: Each new job starts from a zero sum. Nothing from the previous job leaks into it.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_lane` stay unchanged.
- R9: `in_ready` is low whenever no job is taking beats: while idle, and after the last beat until the last lane result has been taken. `busy` falls after the last lane result has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Config strobe, used only while idle |
| cfg_conv | input | 1 | 1 = convolution beat count, 0 = fully connected |
| cfg_k | input | K_W (4) | Kernel side K |
| cfg_cv | input | CV_W (12) | Channel vectors C' |
| busy | output | 1 | A job is in progress |
| in_ready | output | 1 | Engine takes a beat on this edge if both valids are high |
| feat_valid | input | 1 | Feature vector valid |
| feat_data | input | VEC*16 (64) | Shared feature vector |
| wgt_valid | input | 1 | Weight vectors valid |
| wgt_data | input | LANES*VEC*16 (192) | One weight vector per lane |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken on this edge when valid |
| out_lane | output | LANE_W (2) | Lane of the result |
| out_data | output | 32 | Clipped signed result |

## Verification
The hardest behaviour to reach from the ports is a partial sum arriving at the delay line in a cycle when the oldest entry is not the one the previous beat wrote. Reaching it needs beat counts both below and above the line depth, combined with irregular input gaps, so that rotation pauses at varying positions. The stimulus mixes jobs of 1, 3, 6, 8 and 9 beats with and without inserted idle cycles. It also applies random output back-pressure. Because the expected sum does not depend on where each partial lands, any lost or doubled entry shows up as a wrong result.

// File: rtl/mac_eng_pkg.sv
package mac_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_DRAIN = 3'd2,
    ST_RED   = 3'd3,
    ST_OUT   = 3'd4
  } eng_st_e;
endpackage

// File: rtl/mac_add_tree.sv
// Registered binary adder tree; N_IN must be a power of two, at least 2.
module mac_add_tree #(
  parameter int N_IN  = 4,
  parameter int W_IN  = 32,
  parameter int W_OUT = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic                    in_last,
  input  logic [N_IN*W_IN-1:0]    in_data,
  output logic                    out_vld,
  output logic                    out_last,
  output logic signed [W_OUT-1:0] out_sum
);
  localparam int LV = $clog2(N_IN);

  logic signed [W_OUT-1:0] leaf [0:N_IN-1];
  logic signed [W_OUT-1:0] stg  [1:LV][0:N_IN-1];
  logic [LV:1] vp, lp;

  genvar g;
  generate
    for (g = 0; g < N_IN; g++) begin : g_ext
      assign leaf[g] = {{(W_OUT-W_IN){in_data[g*W_IN+W_IN-1]}}, in_data[g*W_IN +: W_IN]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vp <= '0;
      lp <= '0;
    end else begin
      for (int l = 1; l <= LV; l++) begin
        vp[l] <= (l == 1) ? in_vld  : vp[(l-1 < 1) ? 1 : l-1];
        lp[l] <= (l == 1) ? in_last : lp[(l-1 < 1) ? 1 : l-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < N_IN; j++) begin
      if (j < (N_IN >> 1)) stg[1][j] <= leaf[(2*j) % N_IN] + leaf[(2*j+1) % N_IN];
      else                 stg[1][j] <= '0;
    end
    for (int l = 2; l <= LV; l++) begin
      for (int j = 0; j < N_IN; j++) begin
        if (j < (N_IN >> l)) stg[l][j] <= stg[l-1][(2*j) % N_IN] + stg[l-1][(2*j+1) % N_IN];
        else                 stg[l][j] <= '0;
      end
    end
  end

  assign out_vld  = vp[LV];
  assign out_last = lp[LV];
  assign out_sum  = stg[LV][0];
endmodule

// File: rtl/mac_lane.sv
// One lane: products, adder tree, rotating delay line, final reduction with clipping.
module mac_lane #(
  parameter int VEC   = 4,
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int OUT_W = 32,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               beat_vld,
  input  logic               beat_last,
  input  logic [VEC*DW-1:0]  feat,
  input  logic [VEC*DW-1:0]  wgt,
  input  logic               red_en,
  output logic               done,
  output logic [OUT_W-1:0]   result
);
  localparam int PW = 2*DW;
  localparam logic signed [ACC_W-1:0] SMAX = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SMIN = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic [VEC*PW-1:0]       prod_q;
  logic                    pv_q, pl_q;
  logic                    tv, tl;
  logic signed [ACC_W-1:0] tsum;
  logic signed [ACC_W-1:0] dl [0:DEPTH-1];
  logic signed [ACC_W-1:0] total;
  logic                    done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pl_q <= 1'b0;
    end else begin
      pv_q <= beat_vld;
      pl_q <= beat_vld & beat_last;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < VEC; i++) begin
      prod_q[i*PW +: PW] <= PW'($signed(feat[i*DW +: DW])) * PW'($signed(wgt[i*DW +: DW]));
    end
  end

  mac_add_tree #(.N_IN(VEC), .W_IN(PW), .W_OUT(ACC_W)) u_tree (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (pv_q),
    .in_last (pl_q),
    .in_data (prod_q),
    .out_vld (tv),
    .out_last(tl),
    .out_sum (tsum)
  );

  // Delay line rotates only when a partial sum arrives; idle cycles freeze it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) dl[k] <= '0;
      done_q <= 1'b0;
    end else if (clr) begin
      for (int k = 0; k < DEPTH; k++) dl[k] <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= tv & tl;
      if (tv) begin
        dl[0] <= tsum + dl[DEPTH-1];
        for (int k = 1; k < DEPTH; k++) dl[k] <= dl[k-1];
      end
    end
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < DEPTH; k++) total = total + dl[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else if (red_en) begin
      if (total > SMAX)      result <= SMAX[OUT_W-1:0];
      else if (total < SMIN) result <= SMIN[OUT_W-1:0];
      else                   result <= total[OUT_W-1:0];
    end
  end

  assign done = done_q;
endmodule

// File: rtl/mac_seq.sv
// Job sequencer: config latch, beat counting with two-cycle spacing, lane output order.
module mac_seq
  import mac_eng_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int K_W    = 4,
  parameter int CV_W   = 12,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_conv,
  input  logic [K_W-1:0]    cfg_k,
  input  logic [CV_W-1:0]   cfg_cv,
  input  logic              beat_fire,
  input  logic              lanes_done,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              busy,
  output logic              clr,
  output logic              beat_last,
  output logic              red_en,
  output logic              out_valid,
  output logic [LANE_W-1:0] out_lane
);
  localparam int CNT_W = 2*K_W + CV_W;

  eng_st_e          st_q;
  logic [CNT_W-1:0] cnt_q, last_q;
  logic             gap_q;
  logic [LANE_W-1:0] lane_q;
  logic [CNT_W-1:0] kk_w, conv_b, req_b;

  always_comb begin
    kk_w   = CNT_W'(cfg_k) * CNT_W'(cfg_k);
    conv_b = kk_w * CNT_W'(cfg_cv);
    req_b  = cfg_conv ? conv_b : CNT_W'(cfg_cv);
    if (req_b == '0) req_b = CNT_W'(1);
  end

  assign clr       = (st_q == ST_IDLE) && cfg_valid;
  assign in_ready  = (st_q == ST_RUN) && !gap_q;
  assign beat_last = beat_fire && (cnt_q == last_q);
  assign red_en    = (st_q == ST_RED);
  assign out_valid = (st_q == ST_OUT);
  assign busy      = (st_q != ST_IDLE);
  assign out_lane  = lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      last_q <= '0;
      gap_q  <= 1'b0;
      lane_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (cfg_valid) begin
          st_q   <= ST_RUN;
          cnt_q  <= '0;
          gap_q  <= 1'b0;
          last_q <= req_b - CNT_W'(1);
        end
        ST_RUN: begin
          gap_q <= beat_fire;
          if (beat_fire) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == last_q) st_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (lanes_done) st_q <= ST_RED;
        ST_RED: begin
          st_q   <= ST_OUT;
          lane_q <= '0;
        end
        ST_OUT: if (out_ready) begin
          if (lane_q == LANE_W'(LANES-1)) st_q <= ST_IDLE;
          else                            lane_q <= lane_q + LANE_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_delay_engine.sv
module mac_delay_engine #(
  parameter int VEC   = 4,
  parameter int LANES = 3,
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int OUT_W = 32,
  parameter int K_W   = 4,
  parameter int CV_W  = 12,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_valid,
  input  logic                    cfg_conv,
  input  logic [K_W-1:0]          cfg_k,
  input  logic [CV_W-1:0]         cfg_cv,
  output logic                    busy,
  output logic                    in_ready,
  input  logic                    feat_valid,
  input  logic [VEC*DW-1:0]       feat_data,
  input  logic                    wgt_valid,
  input  logic [LANES*VEC*DW-1:0] wgt_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANE_W-1:0]       out_lane,
  output logic [OUT_W-1:0]        out_data
);
  logic             beat_fire, beat_last, clr, red_en;
  logic [LANES-1:0] done_vec;
  logic [OUT_W-1:0] res [0:LANES-1];

  assign beat_fire = in_ready && feat_valid && wgt_valid;

  mac_seq #(.LANES(LANES), .K_W(K_W), .CV_W(CV_W), .LANE_W(LANE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_conv  (cfg_conv),
    .cfg_k     (cfg_k),
    .cfg_cv    (cfg_cv),
    .beat_fire (beat_fire),
    .lanes_done(&done_vec),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .busy      (busy),
    .clr       (clr),
    .beat_last (beat_last),
    .red_en    (red_en),
    .out_valid (out_valid),
    .out_lane  (out_lane)
  );

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      mac_lane #(.VEC(VEC), .DW(DW), .ACC_W(ACC_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .beat_vld (beat_fire),
        .beat_last(beat_last),
        .feat     (feat_data),
        .wgt      (wgt_data[l*VEC*DW +: VEC*DW]),
        .red_en   (red_en),
        .done     (done_vec[l]),
        .result   (res[l])
      );
    end
  endgenerate

  always_comb begin
    out_data = '0;
    for (int i = 0; i < LANES; i++) begin
      if (out_lane == LANE_W'(i)) out_data = res[i];
    end
  end
endmodule

// File: rtl/mac_engine_chk.sv
module mac_engine_chk #(
  parameter int LANES  = 3,
  parameter int OUT_W  = 32,
  parameter int LANE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic              busy,
  input logic              in_ready,
  input logic              feat_valid,
  input logic              wgt_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LANE_W-1:0] out_lane,
  input logic [OUT_W-1:0]  out_data
);
  p_beat_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && feat_valid && wgt_valid |=> !in_ready);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready && !out_valid);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_lane));

  p_lane_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lane < LANE_W'(LANES));

  p_first_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_lane == '0);

  p_cfg_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_valid && !out_valid |=> busy);

  p_no_take_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

bind mac_delay_engine mac_engine_chk #(.LANES(LANES), .OUT_W(OUT_W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .busy      (busy),
  .in_ready  (in_ready),
  .feat_valid(feat_valid),
  .wgt_valid (wgt_valid),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_lane  (out_lane),
  .out_data  (out_data)
);

// File: tb/mac_delay_engine_tb.sv
`timescale 1ns/1ps
module mac_delay_engine_tb;
  localparam int VEC = 4, LANES = 3, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 1'b0, cfg_conv = 1'b0;
  logic [3:0] cfg_k = '0;
  logic [11:0] cfg_cv = '0;
  logic busy, in_ready, out_valid;
  logic feat_valid = 1'b0, wgt_valid = 1'b0, out_ready = 1'b0;
  logic [VEC*DW-1:0] feat_data = '0;
  logic [LANES*VEC*DW-1:0] wgt_data = '0;
  logic [1:0] out_lane;
  logic [31:0] out_data;

  int total = 0, bad = 0, cyc = 0;
  int qlane[$];
  longint qval[$];
  string cur_tag = "R3";
  bit rand_ready = 0;

  always #10 clk = ~clk;

  mac_delay_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_conv(cfg_conv),
    .cfg_k(cfg_k), .cfg_cv(cfg_cv), .busy(busy), .in_ready(in_ready),
    .feat_valid(feat_valid), .feat_data(feat_data), .wgt_valid(wgt_valid),
    .wgt_data(wgt_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_lane(out_lane), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint clip32(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  // Output side: drive ready, then compare against the model queue.
  logic pv_ov = 0, pv_or = 0;
  logic [31:0] pv_data = '0;
  logic [1:0] pv_lane = '0;
  always @(negedge clk) begin
    cyc++;
    out_ready = rand_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
    if (rst_n && pv_ov && !pv_or) begin
      chk(out_valid && out_data == pv_data && out_lane == pv_lane, "R8",
          "held result", longint'($signed(out_data)), longint'($signed(pv_data)));
    end
    if (rst_n && out_valid && out_ready) begin
      if (qval.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected result", longint'($signed(out_data)), 0);
      end else begin
        chk(int'(out_lane) == qlane[0], cur_tag, "lane index", out_lane, qlane[0]);
        chk(longint'($signed(out_data)) == qval[0], cur_tag, "lane result",
            longint'($signed(out_data)), qval[0]);
        void'(qlane.pop_front());
        void'(qval.pop_front());
      end
    end
    pv_ov = out_valid; pv_or = out_ready; pv_data = out_data; pv_lane = out_lane;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // R4: no acceptance in the cycle after an acceptance.
  bit prev_acc = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_acc) chk(!in_ready, "R4", "ready after beat", in_ready, 0);
      prev_acc = in_ready && feat_valid && wgt_valid;
    end
  end

  task automatic send(input logic [VEC*DW-1:0] f, input logic [LANES*VEC*DW-1:0] w);
    bit got = 0;
    while (!got) begin
      @(negedge clk);
      feat_valid = 1'b1; wgt_valid = 1'b1; feat_data = f; wgt_data = w;
      if (in_ready) begin
        @(posedge clk);
        got = 1;
      end
    end
  endtask

  task automatic run_job(input bit conv, input int k, input int cv, input bit gaps,
                         input bit sat, input bit poke, input string tag);
    int beats;
    longint acc [LANES];
    cur_tag = tag;
    @(negedge clk);
    chk(!busy && !in_ready, "R9", "idle before config", {busy, in_ready}, 0);
    cfg_valid = 1'b1; cfg_conv = conv; cfg_k = 4'(k); cfg_cv = 12'(cv);
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(busy, "R2", "busy after config", busy, 1);
    beats = conv ? k*k*cv : cv;
    if (beats == 0) beats = 1;
    for (int l = 0; l < LANES; l++) acc[l] = 0;
    for (int b = 0; b < beats; b++) begin
      logic [VEC*DW-1:0] f;
      logic [LANES*VEC*DW-1:0] w;
      for (int i = 0; i < VEC; i++) begin
        int fv;
        fv = sat ? 32767 : ($urandom_range(0, 4000) - 2000);
        f[i*DW +: DW] = 16'(fv);
        for (int l = 0; l < LANES; l++) begin
          int wv;
          wv = sat ? ((l % 2 == 0) ? 32767 : -32768) : ($urandom_range(0, 4000) - 2000);
          w[(l*VEC+i)*DW +: DW] = 16'(wv);
          acc[l] += longint'(fv) * longint'(wv);
        end
      end
      if (gaps && (b % 2 == 1)) begin
        repeat (1 + b % 3) begin
          @(negedge clk);
          feat_valid = 1'b0; wgt_valid = (b % 4 == 1);
        end
      end
      send(f, w);
      if (poke && b == 0) begin
        @(negedge clk);
        feat_valid = 1'b0; wgt_valid = 1'b0;
        cfg_valid = 1'b1; cfg_conv = 1'b1; cfg_k = 4'd3; cfg_cv = 12'd5;
        @(negedge clk);
        cfg_valid = 1'b0;
      end
    end
    @(negedge clk);
    feat_valid = 1'b0; wgt_valid = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      qlane.push_back(l);
      qval.push_back(clip32(acc[l]));
    end
    while (qval.size() > 0) @(negedge clk);
    @(negedge clk);
    #2;
    chk(!busy, "R9", "busy cleared after last result", busy, 0);
    chk(!in_ready, "R9", "ready low after job", in_ready, 0);
  endtask

  initial begin
    #3;
    chk(!busy && !in_ready && !out_valid, "R1", "in reset", {busy, in_ready, out_valid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !in_ready && !out_valid, "R1", "after reset", {busy, in_ready, out_valid}, 0);
    run_job(0, 0, 3, 0, 0, 0, "R3");  // fc, 3 beats
    run_job(1, 2, 2, 0, 0, 0, "R2");  // conv, 8 beats, wraps the delay line
    run_job(0, 0, 1, 0, 0, 0, "R7");  // single beat must not see previous sums
    run_job(0, 0, 0, 0, 0, 0, "R2");  // zero count taken as one beat
    rand_ready = 1;
    run_job(1, 3, 1, 1, 0, 0, "R5");  // 9 beats with gaps, back-pressure for R8
    run_job(0, 0, 2, 0, 1, 0, "R6");  // clipping both directions
    run_job(0, 0, 5, 0, 0, 1, "R2");  // config pulse while busy is ignored
    run_job(1, 1, 6, 1, 0, 0, "R5");  // 6 beats, gaps, random ready
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule